// File: doc/BRIEF.md
# Write-Merging Posting Buffer

This block sits in a bus bridge between an upstream port that posts writes and a downstream port that carries them on as bursts. Each upstream item is one word write: a word address, a data word and one enable bit per byte lane, plus a flag that marks an I/O access. Memory writes are gathered into one pending burst and leave downstream as a run of data phases with consecutive word addresses. Each phase has its own byte enables and marks for the first and last phase.

Two writes to the same word whose byte enables do not overlap become one phase carrying the union of both sets of enables. A write that lands a short distance past the tail of the burst lengthens it. The skipped words are filled with phases whose enables are all off. A write that would touch a byte lane already written in the tail word is never folded in. It closes the burst instead, so both writes reach the downstream side in arrival order. I/O writes are never merged: any pending burst is sent out first, and then the I/O write goes out alone, unchanged.

The pending burst also leaves after a set number of cycles without new input, or at once when the flush input is raised. Both ports use valid/ready handshakes.

Top module: `wmb_post_buffer`

## Requirements
- R1: After reset the buffer holds nothing: `out_valid` is 0 and `in_ready` is 1.
- R2: A memory write to the same word as the burst's tail, with no byte enable in common with it, merges into that phase. The phase carries the OR of the enables and each write's bytes on its own lanes. Lanes with the enable off carry zero data.
- R3: A memory write to the tail word that shares any enabled byte lane with it is not merged. The burst closes and drains first, then the write is accepted, so both writes appear downstream in arrival order.
- R4: A memory write to word `tail+1+g`, where g is at most MAX_GAP, extends the burst. The g skipped words are emitted as filler phases with `out_be` = 0 and data 0. A larger gap, or an address below the tail, closes the burst.
- R5: No burst has more than MAX_BURST phases. A write that would put a phase at offset MAX_BURST or beyond from the burst base closes the burst.
- R6: An I/O write (`in_io` = 1) first causes any pending memory burst to drain. It is then emitted alone as a single phase with `out_first` = `out_last` = 1, `out_io` = 1, and its address, data and enables unchanged.
- R7: A pending burst that accepts no write for IDLE_CYCLES cycles starts draining. Its first phase appears IDLE_CYCLES+1 cycles after the last accepted write.
- R8: `flush` closes a pending burst at once. In a cycle where `flush` is high and a burst is pending, `in_ready` is 0 even if the offered write could merge.
- R9: Within a burst the phases have consecutive addresses starting at the base word. `out_first` is set only on the first phase and `out_last` only on the last. Writes leave in the order they arrived.
- R10: While phases are being emitted, `in_ready` is 0. A phase that is stalled by `out_ready` = 0 keeps its address, data, enables and last mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Upstream write offered |
| in_ready | output | 1 | Upstream write taken this cycle |
| in_addr | input | AW | Word address of the write |
| in_data | input | DW | Write data |
| in_be | input | DW/8 | Byte-lane enables |
| in_io | input | 1 | Write is an I/O access |
| flush | input | 1 | Close the pending burst now |
| out_valid | output | 1 | Downstream data phase valid |
| out_ready | input | 1 | Downstream accepts the phase |
| out_addr | output | AW | Word address of the phase |
| out_data | output | DW | Phase data |
| out_be | output | DW/8 | Phase byte enables (0 on filler phases) |
| out_first | output | 1 | First phase of a burst |
| out_last | output | 1 | Last phase of a burst |
| out_io | output | 1 | Phase carries an I/O write |

## Verification
The two functions that can fall in the same cycle are the explicit flush and the merge of an incoming write into the tail word. The bench sets up a one-byte pending burst, then raises `flush` in the same cycle that it offers a write to a disjoint lane of the same word. It expects `in_ready` to be low in that cycle. It then expects the old phase to drain unmerged, followed by the offered write as a burst of its own. A second case of the same kind lets the idle timer expire at a fixed cycle count. It checks that no phase appears one cycle early and that a phase does appear in the expected cycle.

// File: rtl/wmb_pkg.sv
package wmb_pkg;
   typedef enum logic {
      WMB_FILL  = 1'b0,
      WMB_DRAIN = 1'b1
   } wmb_mode_e;
endpackage

// File: rtl/wmb_lane_store.sv
module wmb_lane_store #(
   parameter int DW    = 32,
   parameter int DEPTH = 8,
   localparam int BEW  = DW / 8,
   localparam int IW   = $clog2(DEPTH)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic           wr_en,
   input  logic [IW-1:0]  wr_idx,
   input  logic [DW-1:0]  wr_data,
   input  logic [BEW-1:0] wr_be,
   input  logic [IW-1:0]  rd_idx,
   output logic [DW-1:0]  rd_data,
   output logic [BEW-1:0] rd_be,
   input  logic [IW-1:0]  tl_idx,
   output logic [BEW-1:0] tl_be
);
   logic [DW-1:0]  data_q [DEPTH];
   logic [BEW-1:0] be_q   [DEPTH];

   for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n || clr) begin
            data_q[s] <= '0;
            be_q[s]   <= '0;
         end else if (wr_en && (wr_idx == IW'(s))) begin
            for (int b = 0; b < BEW; b++) begin
               if (wr_be[b]) begin
                  data_q[s][b*8 +: 8] <= wr_data[b*8 +: 8];
               end
            end
            be_q[s] <= be_q[s] | wr_be;
         end
      end
   end

   assign rd_data = data_q[rd_idx];
   assign rd_be   = be_q[rd_idx];
   assign tl_be   = be_q[tl_idx];
endmodule

// File: rtl/wmb_window.sv
module wmb_window #(
   parameter int AW        = 16,
   parameter int BEW       = 4,
   parameter int MAX_BURST = 8,
   parameter int MAX_GAP   = 1,
   localparam int IW       = $clog2(MAX_BURST),
   localparam int LW       = $clog2(MAX_BURST + 1)
) (
   input  logic           active,
   input  logic [AW-1:0]  base,
   input  logic [LW-1:0]  len,
   input  logic [BEW-1:0] tail_be,
   input  logic [AW-1:0]  in_addr,
   input  logic [BEW-1:0] in_be,
   input  logic           in_io,
   output logic           fits,
   output logic [IW-1:0]  slot_idx
);
   logic [AW-1:0] off;
   logic [AW-1:0] tail_w;
   logic          same_word;
   logic          lanes_free;
   logic          past_tail;
   logic          near;
   logic          in_room;

   assign off        = in_addr - base;
   assign tail_w     = AW'(len) - AW'(1);
   assign same_word  = (off == tail_w);
   assign lanes_free = ((in_be & tail_be) == '0);
   assign past_tail  = (off > tail_w);
   assign in_room    = (off < AW'(MAX_BURST));

   if (MAX_GAP == 0) begin : g_tight
      assign near = (off == tail_w + AW'(1));
   end else begin : g_gapped
      assign near = ((off - tail_w) <= AW'(MAX_GAP + 1));
   end

   assign fits     = active && !in_io &&
                     ((same_word && lanes_free) || (past_tail && near && in_room));
   assign slot_idx = active ? off[IW-1:0] : '0;
endmodule

// File: rtl/wmb_post_buffer.sv
module wmb_post_buffer
   import wmb_pkg::*;
#(
   parameter int AW          = 16,
   parameter int DW          = 32,
   parameter int MAX_BURST   = 8,
   parameter int MAX_GAP     = 1,
   parameter int IDLE_CYCLES = 16,
   localparam int BEW        = DW / 8,
   localparam int IW         = $clog2(MAX_BURST),
   localparam int LW         = $clog2(MAX_BURST + 1),
   localparam int CW         = $clog2(IDLE_CYCLES + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           in_valid,
   output logic           in_ready,
   input  logic [AW-1:0]  in_addr,
   input  logic [DW-1:0]  in_data,
   input  logic [BEW-1:0] in_be,
   input  logic           in_io,
   input  logic           flush,
   output logic           out_valid,
   input  logic           out_ready,
   output logic [AW-1:0]  out_addr,
   output logic [DW-1:0]  out_data,
   output logic [BEW-1:0] out_be,
   output logic           out_first,
   output logic           out_last,
   output logic           out_io
);
   if (DW % 8 != 0 || DW < 8) begin : g_bad_dw
      $error("wmb_post_buffer: DW must be a positive multiple of 8");
   end
   if (MAX_BURST < 2) begin : g_bad_burst
      $error("wmb_post_buffer: MAX_BURST must be at least 2");
   end
   if (MAX_GAP < 0 || MAX_GAP > MAX_BURST - 2) begin : g_bad_gap
      $error("wmb_post_buffer: MAX_GAP must lie in 0..MAX_BURST-2");
   end
   if (IDLE_CYCLES < 1) begin : g_bad_idle
      $error("wmb_post_buffer: IDLE_CYCLES must be at least 1");
   end
   if (AW < IW + 1) begin : g_bad_aw
      $error("wmb_post_buffer: AW too narrow for MAX_BURST");
   end

   wmb_mode_e      mode_q;
   logic           active_q;
   logic           io_q;
   logic [AW-1:0]  base_q;
   logic [LW-1:0]  len_q;
   logic [IW-1:0]  rd_ptr_q;
   logic [CW-1:0]  idle_q;

   logic           fits;
   logic [IW-1:0]  slot_idx;
   logic [BEW-1:0] tail_be;
   logic           idle_hit;
   logic           close;
   logic           in_fire;
   logic           out_fire;
   logic           last_ph;
   logic           clr;
   logic [IW-1:0]  tail_idx;

   assign tail_idx = IW'(len_q - LW'(1));
   assign idle_hit = (idle_q >= CW'(IDLE_CYCLES));
   assign close    = (mode_q == WMB_FILL) && active_q &&
                     (flush || idle_hit || (in_valid && !fits));
   assign in_ready = (mode_q == WMB_FILL) && !close;
   assign in_fire  = in_valid && in_ready;
   assign out_fire = out_valid && out_ready;
   assign last_ph  = (LW'(rd_ptr_q) == len_q - LW'(1));
   assign clr      = out_fire && last_ph;

   wmb_window #(
      .AW(AW), .BEW(BEW), .MAX_BURST(MAX_BURST), .MAX_GAP(MAX_GAP)
   ) u_window (
      .active  (active_q),
      .base    (base_q),
      .len     (len_q),
      .tail_be (tail_be),
      .in_addr (in_addr),
      .in_be   (in_be),
      .in_io   (in_io),
      .fits    (fits),
      .slot_idx(slot_idx)
   );

   wmb_lane_store #(
      .DW(DW), .DEPTH(MAX_BURST)
   ) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr),
      .wr_en  (in_fire),
      .wr_idx (slot_idx),
      .wr_data(in_data),
      .wr_be  (in_be),
      .rd_idx (rd_ptr_q),
      .rd_data(out_data),
      .rd_be  (out_be),
      .tl_idx (tail_idx),
      .tl_be  (tail_be)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q   <= WMB_FILL;
         active_q <= 1'b0;
         io_q     <= 1'b0;
         base_q   <= '0;
         len_q    <= '0;
         rd_ptr_q <= '0;
         idle_q   <= '0;
      end else if (mode_q == WMB_FILL) begin
         if (close) begin
            mode_q   <= WMB_DRAIN;
            rd_ptr_q <= '0;
         end else if (in_fire) begin
            idle_q <= '0;
            if (!active_q) begin
               active_q <= 1'b1;
               base_q   <= in_addr;
               len_q    <= LW'(1);
               io_q     <= in_io;
               if (in_io) begin
                  mode_q <= WMB_DRAIN;
               end
            end else begin
               len_q <= LW'(slot_idx) + LW'(1);
            end
         end else if (active_q && !idle_hit) begin
            idle_q <= idle_q + CW'(1);
         end
      end else if (out_ready) begin
         if (last_ph) begin
            mode_q   <= WMB_FILL;
            active_q <= 1'b0;
            io_q     <= 1'b0;
            len_q    <= '0;
            rd_ptr_q <= '0;
            idle_q   <= '0;
         end else begin
            rd_ptr_q <= rd_ptr_q + IW'(1);
         end
      end
   end

   assign out_valid = (mode_q == WMB_DRAIN);
   assign out_addr  = base_q + AW'(rd_ptr_q);
   assign out_first = out_valid && (rd_ptr_q == '0);
   assign out_last  = out_valid && last_ph;
   assign out_io    = out_valid && io_q;
endmodule

// File: rtl/wmb_post_buffer_chk.sv
module wmb_post_buffer_chk #(
   parameter int AW        = 16,
   parameter int DW        = 32,
   parameter int MAX_BURST = 8,
   localparam int BEW      = DW / 8,
   localparam int KW       = $clog2(MAX_BURST + 1) + 1
) (
   input logic           clk,
   input logic           rst_n,
   input logic           in_ready,
   input logic           out_valid,
   input logic           out_ready,
   input logic [AW-1:0]  out_addr,
   input logic [DW-1:0]  out_data,
   input logic [BEW-1:0] out_be,
   input logic           out_first,
   input logic           out_last,
   input logic           out_io
);
   logic [KW-1:0] beat_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         beat_cnt <= '0;
      end else if (out_valid && out_ready) begin
         beat_cnt <= out_last ? '0 : beat_cnt + KW'(1);
      end
   end

   a_r10_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_data)
                                  && $stable(out_be) && $stable(out_last));

   a_r10_no_intake_while_draining: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready);

   a_r9_address_steps: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready && !out_last |=>
         out_valid && !out_first && (out_addr == $past(out_addr) + AW'(1)));

   a_r9_first_marks_start: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_first == (beat_cnt == '0)));

   a_r5_burst_bound: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (beat_cnt < KW'(MAX_BURST)));

   a_r6_io_alone: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_io |-> out_first && out_last);
endmodule

bind wmb_post_buffer wmb_post_buffer_chk #(
   .AW(AW), .DW(DW), .MAX_BURST(MAX_BURST)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_ready (in_ready),
   .out_valid(out_valid),
   .out_ready(out_ready),
   .out_addr (out_addr),
   .out_data (out_data),
   .out_be   (out_be),
   .out_first(out_first),
   .out_last (out_last),
   .out_io   (out_io)
);

// File: tb/wmb_post_buffer_bench.sv
module wmb_post_buffer_bench;
   localparam int AW = 16;
   localparam int DW = 32;
   localparam int MB = 8;
   localparam int GAP = 1;
   localparam int IDLE = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [AW-1:0] in_addr = '0;
   logic [DW-1:0] in_data = '0;
   logic [3:0]    in_be = '0;
   logic          in_io = 1'b0;
   logic          flush = 1'b0;
   logic          out_valid;
   logic          out_ready = 1'b1;
   logic [AW-1:0] out_addr;
   logic [DW-1:0] out_data;
   logic [3:0]    out_be;
   logic          out_first;
   logic          out_last;
   logic          out_io;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [54:0] exp_q [$];
   string       tag_q [$];

   always #10 clk = ~clk;

   wmb_post_buffer #(
      .AW(AW), .DW(DW), .MAX_BURST(MB), .MAX_GAP(GAP), .IDLE_CYCLES(IDLE)
   ) u_wmb_post_buffer (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
      .in_data(in_data), .in_be(in_be), .in_io(in_io), .flush(flush),
      .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
      .out_data(out_data), .out_be(out_be), .out_first(out_first),
      .out_last(out_last), .out_io(out_io)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic expect_ph(input logic [AW-1:0] a, input logic [31:0] d,
                            input logic [3:0] be, input bit f, input bit l,
                            input bit io, input string req);
      exp_q.push_back({a, d, be, f, l, io});
      tag_q.push_back(req);
   endtask

   // caller is 2 ns after a rising edge; returns in the same phase
   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d,
                     input logic [3:0] be, input bit io);
      in_valid = 1'b1; in_addr = a; in_data = d; in_be = be; in_io = io;
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      @(posedge clk); #2;
      in_valid = 1'b0;
   endtask

   task automatic do_flush();
      flush = 1'b1;
      @(posedge clk); #2;
      flush = 1'b0;
   endtask

   task automatic drain_wait();
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (exp_q.size() == 0 && !out_valid) break;
      end
      @(posedge clk); #2;
   endtask

   // scoreboard monitor
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && out_valid && out_ready) begin
            logic [54:0] got;
            got = {out_addr, out_data, out_be, out_first, out_last, out_io};
            if (exp_q.size() == 0) begin
               check(1'b0, "R9 unexpected phase", 64'(got), 64'(0));
            end else begin
               logic [54:0] want;
               string req;
               want = exp_q.pop_front();
               req  = tag_q.pop_front();
               check(got == want, req, 64'(got), 64'(want));
            end
         end
      end
   end

   initial begin
      #(20 * 20000);
      if (!done) begin
         done = 1'b1;
         failures++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0, "R1 out_valid after reset", 64'(out_valid), 64'(0));
      check(in_ready == 1'b1, "R1 in_ready after reset", 64'(in_ready), 64'(1));
      @(posedge clk); #2;

      // R2: disjoint lanes of one word merge
      expect_ph(16'h0010, 32'h0000_BBAA, 4'b0011, 1, 1, 0, "R2 merged phase");
      wr(16'h0010, 32'h1234_56AA, 4'b0001, 0);
      wr(16'h0010, 32'h9876_BB54, 4'b0010, 0);
      do_flush();
      drain_wait();

      // R3: overlapping lanes are never combined, order kept
      expect_ph(16'h0020, 32'h0000_1111, 4'b0011, 1, 1, 0, "R3 earlier write kept");
      expect_ph(16'h0020, 32'h0022_2200, 4'b0110, 1, 1, 0, "R3 later write separate");
      wr(16'h0020, 32'h1111_1111, 4'b0011, 0);
      wr(16'h0020, 32'h2222_2222, 4'b0110, 0);
      do_flush();
      drain_wait();

      // R4: gap of one word bridged by a filler phase
      expect_ph(16'h0030, 32'hA0A0_A0A0, 4'b1111, 1, 0, 0, "R4 gap burst head");
      expect_ph(16'h0031, 32'h0000_0000, 4'b0000, 0, 0, 0, "R4 filler phase");
      expect_ph(16'h0032, 32'hB0B0_B0B0, 4'b1111, 0, 1, 0, "R4 gap burst tail");
      wr(16'h0030, 32'hA0A0_A0A0, 4'b1111, 0);
      wr(16'h0032, 32'hB0B0_B0B0, 4'b1111, 0);
      do_flush();
      drain_wait();

      // R4: gap of two words is too wide; R9: descending address splits
      expect_ph(16'h0040, 32'h4040_4040, 4'b1111, 1, 1, 0, "R4 wide gap first");
      expect_ph(16'h0043, 32'h4343_4343, 4'b1111, 1, 1, 0, "R4 wide gap second");
      expect_ph(16'h0071, 32'h7171_7171, 4'b1111, 1, 1, 0, "R9 higher word first");
      expect_ph(16'h0070, 32'h7070_7070, 4'b1111, 1, 1, 0, "R9 lower word after");
      wr(16'h0040, 32'h4040_4040, 4'b1111, 0);
      wr(16'h0043, 32'h4343_4343, 4'b1111, 0);
      wr(16'h0071, 32'h7171_7171, 4'b1111, 0);
      wr(16'h0070, 32'h7070_7070, 4'b1111, 0);
      do_flush();
      drain_wait();

      // R5: burst capped at MAX_BURST phases
      for (int i = 0; i < MB; i++) begin
         expect_ph(AW'(16'h0050 + i), 32'h5000_0000 + 32'(i), 4'b1111,
                   i == 0, i == MB - 1, 0, "R5 capped burst");
      end
      expect_ph(AW'(16'h0050 + MB), 32'h5000_0000 + 32'(MB), 4'b1111, 1, 1, 0,
                "R5 overflow write alone");
      for (int i = 0; i <= MB; i++) begin
         wr(AW'(16'h0050 + i), 32'h5000_0000 + 32'(i), 4'b1111, 0);
      end
      do_flush();
      drain_wait();

      // R6: I/O write drains pending burst, then goes alone
      expect_ph(16'h0060, 32'hCCCC_CCCC, 4'b1111, 1, 1, 0, "R6 pending memory first");
      expect_ph(16'h0061, 32'h00DD_0000, 4'b0100, 1, 1, 1, "R6 io write alone");
      wr(16'h0060, 32'hCCCC_CCCC, 4'b1111, 0);
      wr(16'h0061, 32'h00DD_0000, 4'b0100, 1);
      drain_wait();

      // R8: flush and a mergeable write in the same cycle
      expect_ph(16'h0080, 32'h0000_00EE, 4'b0001, 1, 1, 0, "R8 flushed phase unmerged");
      expect_ph(16'h0080, 32'h0000_FF00, 4'b0010, 1, 1, 0, "R8 held write later");
      wr(16'h0080, 32'h0000_00EE, 4'b0001, 0);
      in_valid = 1'b1; in_addr = 16'h0080; in_data = 32'h0000_FF00;
      in_be = 4'b0010; in_io = 1'b0; flush = 1'b1;
      @(negedge clk);
      check(in_ready == 1'b0, "R8 in_ready with flush", 64'(in_ready), 64'(0));
      @(posedge clk); #2;
      flush = 1'b0;
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      @(posedge clk); #2;
      in_valid = 1'b0;
      do_flush();
      drain_wait();

      // R7: idle timeout
      expect_ph(16'h0090, 32'h9090_9090, 4'b1111, 1, 1, 0, "R7 idle flushed phase");
      wr(16'h0090, 32'h9090_9090, 4'b1111, 0);
      repeat (IDLE + 1) @(negedge clk);
      check(out_valid == 1'b0, "R7 not before timeout", 64'(out_valid), 64'(0));
      @(negedge clk);
      check(out_valid == 1'b1, "R7 drain at timeout", 64'(out_valid), 64'(1));
      @(posedge clk); #2;
      drain_wait();

      // R10: stalled phase held, no intake while draining
      expect_ph(16'h00A0, 32'hA1A1_A1A1, 4'b1111, 1, 0, 0, "R10 stalled head");
      expect_ph(16'h00A1, 32'hA2A2_A2A2, 4'b1111, 0, 1, 0, "R10 stalled tail");
      wr(16'h00A0, 32'hA1A1_A1A1, 4'b1111, 0);
      wr(16'h00A1, 32'hA2A2_A2A2, 4'b1111, 0);
      out_ready = 1'b0;
      do_flush();
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check(out_valid && out_addr == 16'h00A0, "R10 stalled phase held",
               64'(out_addr), 64'(16'h00A0));
         check(in_ready == 1'b0, "R10 no intake while draining", 64'(in_ready), 64'(0));
      end
      @(posedge clk); #2;
      out_ready = 1'b1;
      drain_wait();

      check(exp_q.size() == 0, "R9 all expected phases seen", 64'(exp_q.size()), 64'(0));
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule